// File: doc/BRIEF.md
# NAND Flash Register Bridge

This block lets a processor run a raw 8-bit NAND flash device through a single 32-bit register. A register write carries three things: an operation code, a chip-enable flag and a data byte. The bridge turns a command, address or data-write operation into a complete, timed latch cycle on the flash pins. Each cycle has a setup phase, a WE# pulse and a hold phase.

A write with the read-arm operation code puts the bridge into streaming read mode. In that mode every plain register read runs one timed RE# cycle, and the flash byte captured at the end of the pulse comes back in the read data. Every register read also reports the flash ready/busy line, taken through a synchroniser.

A register access is stalled with a wait signal while a flash cycle is in progress. The host holds its strobe until wait is low at a clock edge.

Top module: `nand_reg_bridge`

## Requirements
- R1: Bits 30:28 of a register write select the operation: 0 runs a command cycle, 1 runs an address cycle, 3 runs a data-write cycle, 2 arms read mode and runs no cycle, and the values 4 to 7 run no flash cycle.
- R2: Every completed register write copies its bit 31 to the chip enable: 1 drives nand_ce_n low and 0 drives it high.
- R3: A command cycle drives nand_cle high and nand_ale low, with nand_io_oe high and nand_io_out equal to write bits 23:16. These stay from T_SETUP cycles before nand_we_n goes low until T_HOLD cycles after it returns high. nand_we_n stays low for exactly T_PULSE cycles.
- R4: An address cycle has the same timing as R3, with nand_ale high and nand_cle low.
- R5: A data-write cycle has the same timing as R3, with both nand_cle and nand_ale low.
- R6: While read mode is armed, each register read produces one nand_re_n low pulse of T_PULSE cycles, with nand_io_oe low throughout. Successive reads return successive flash bytes in read bits 23:16. Each byte is the value of nand_io_in at the last cycle of the pulse.
- R7: A register read while read mode is not armed starts no RE# pulse, completes without wait, and returns the last captured byte (0 after reset).
- R8: Any completed register write whose operation code is not 2 leaves read mode.
- R9: Read bit 15 is 1 exactly when nand_rb_n is low, delayed by two clock edges through a synchroniser. All read bits other than 23:16 and 15 are zero.
- R10: An access that needs a flash cycle holds reg_wait high for 1 + T_SETUP + T_PULSE + T_HOLD cycles, then low for the completing cycle. An access that needs no cycle completes with reg_wait low.
- R11: nand_we_n and nand_re_n are never low together, and nand_cle and nand_ale are never high together.
- R12: After reset, nand_ce_n, nand_we_n and nand_re_n are high, nand_cle, nand_ale and nand_io_oe are low, and the register reads as zero while nand_rb_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, held until reg_wait is low |
| reg_rd | input | 1 | Register read strobe, held until reg_wait is low |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_wait | output | 1 | Stalls the current access while high |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_io_out | output | 8 | Flash IO bus, driven value |
| nand_io_oe | output | 1 | Flash IO bus output enable |
| nand_io_in | input | 8 | Flash IO bus, sampled value |
| nand_rb_n | input | 1 | Flash ready/busy, low when busy |

## Verification
The bench sweeps all eight operation codes with both chip-enable values and several data bytes. After each write it issues a plain read, so a single pass separates the three latch cycles from one another, from the read-arm code and from the codes with no cycle. It also shows whether each write left read mode armed or disarmed. A full sweep of all 256 data bytes on data-write cycles finds IO bus bit errors. Runs of streaming reads against a flash model whose byte changes on every fetch tell a fresh capture apart from a stale one. A ready/busy toggle tells the synchroniser latency apart from a direct path.

// File: rtl/nrb_pkg.sv
package nrb_pkg;

    typedef enum logic [1:0] {
        KIND_CMD,
        KIND_ADR,
        KIND_WR,
        KIND_RD
    } kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD,
        PH_DONE
    } phase_e;

    localparam logic [2:0] OP_CMD   = 3'd0;
    localparam logic [2:0] OP_ADR   = 3'd1;
    localparam logic [2:0] OP_ARM   = 3'd2;
    localparam logic [2:0] OP_WRITE = 3'd3;

    localparam int unsigned ENA_BIT  = 31;
    localparam int unsigned OP_HI    = 30;
    localparam int unsigned OP_LO    = 28;
    localparam int unsigned BYTE_HI  = 23;
    localparam int unsigned BYTE_LO  = 16;
    localparam int unsigned BUSY_BIT = 15;

endpackage

// File: rtl/nrb_sync.sv
module nrb_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/nrb_seq.sv
module nrb_seq
    import nrb_pkg::*;
#(
    parameter int unsigned T_SETUP = 2,
    parameter int unsigned T_PULSE = 3,
    parameter int unsigned T_HOLD  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  kind_e      kind,
    input  logic [7:0] obyte,
    input  logic [7:0] io_in,
    output logic       idle,
    output logic       done,
    output logic       we_n,
    output logic       re_n,
    output logic       cle,
    output logic       ale,
    output logic       oe,
    output logic [7:0] io_out,
    output logic [7:0] cap
);
    localparam int unsigned T_MAX1 = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
    localparam int unsigned T_MAX  = (T_MAX1 > T_HOLD) ? T_MAX1 : T_HOLD;
    localparam int unsigned CNT_W  = $clog2(T_MAX + 1);

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(T_SETUP - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(T_PULSE - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(T_HOLD - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        kind_e            kind;
        logic [7:0]       obyte;
        logic [7:0]       cap;
        logic             we_n;
        logic             re_n;
        logic             cle;
        logic             ale;
        logic             oe;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        ph: PH_IDLE, cnt: '0, kind: KIND_CMD, obyte: 8'h00, cap: 8'h00,
        we_n: 1'b1, re_n: 1'b1, cle: 1'b0, ale: 1'b0, oe: 1'b0
    };

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph    = PH_SETUP;
                    s_d.cnt   = LD_SETUP;
                    s_d.kind  = kind;
                    s_d.obyte = obyte;
                    s_d.cle   = (kind == KIND_CMD);
                    s_d.ale   = (kind == KIND_ADR);
                    s_d.oe    = (kind != KIND_RD);
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_PULSE;
                    s_d.cnt = LD_PULSE;
                    if (s_q.kind == KIND_RD) s_d.re_n = 1'b0;
                    else                     s_d.we_n = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_PULSE: begin
                if (s_q.cnt == '0) begin
                    s_d.ph   = PH_HOLD;
                    s_d.cnt  = LD_HOLD;
                    s_d.we_n = 1'b1;
                    s_d.re_n = 1'b1;
                    if (s_q.kind == KIND_RD) s_d.cap = io_in;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_DONE;
                    s_d.cle = 1'b0;
                    s_d.ale = 1'b0;
                    s_d.oe  = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_DONE: s_d.ph = PH_IDLE;
            default: s_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RST;
        else        s_q <= s_d;
    end

    assign idle   = (s_q.ph == PH_IDLE);
    assign done   = (s_q.ph == PH_DONE);
    assign we_n   = s_q.we_n;
    assign re_n   = s_q.re_n;
    assign cle    = s_q.cle;
    assign ale    = s_q.ale;
    assign oe     = s_q.oe;
    assign io_out = s_q.obyte;
    assign cap    = s_q.cap;
endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge
    import nrb_pkg::*;
#(
    parameter int unsigned T_SETUP     = 2,
    parameter int unsigned T_PULSE     = 3,
    parameter int unsigned T_HOLD      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_wait,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_io_out,
    output logic        nand_io_oe,
    input  logic [7:0]  nand_io_in,
    input  logic        nand_rb_n
);
    typedef struct packed {
        logic ce;
        logic armed;
    } ctl_t;

    ctl_t c_d, c_q;

    logic       seq_idle, seq_done, seq_start;
    kind_e      seq_kind;
    logic [7:0] cap_byte;
    logic       rb_sync;
    logic       needs_cycle;
    logic [2:0] op;
    logic       unused_wbits;

    assign op           = reg_wdata[OP_HI:OP_LO];
    assign unused_wbits = ^{reg_wdata[27:24], reg_wdata[15:0]};

    always_comb begin
        c_d         = c_q;
        seq_kind    = KIND_RD;
        needs_cycle = 1'b0;
        if (reg_wr) begin
            unique case (op)
                OP_CMD:   begin seq_kind = KIND_CMD; needs_cycle = 1'b1; end
                OP_ADR:   begin seq_kind = KIND_ADR; needs_cycle = 1'b1; end
                OP_WRITE: begin seq_kind = KIND_WR;  needs_cycle = 1'b1; end
                default:  begin seq_kind = KIND_RD;  needs_cycle = 1'b0; end
            endcase
        end else if (reg_rd) begin
            seq_kind    = KIND_RD;
            needs_cycle = c_q.armed;
        end
        seq_start = seq_idle && needs_cycle;
        if (seq_idle && reg_wr) begin
            c_d.ce    = reg_wdata[ENA_BIT];
            c_d.armed = (op == OP_ARM);
        end
        reg_wait = (reg_wr || reg_rd) && !seq_done && (!seq_idle || needs_cycle);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{ce: 1'b0, armed: 1'b0};
        else        c_q <= c_d;
    end

    nrb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rb_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (nand_rb_n),
        .dout (rb_sync)
    );

    nrb_seq #(.T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (seq_start),
        .kind  (seq_kind),
        .obyte (reg_wdata[BYTE_HI:BYTE_LO]),
        .io_in (nand_io_in),
        .idle  (seq_idle),
        .done  (seq_done),
        .we_n  (nand_we_n),
        .re_n  (nand_re_n),
        .cle   (nand_cle),
        .ale   (nand_ale),
        .oe    (nand_io_oe),
        .io_out(nand_io_out),
        .cap   (cap_byte)
    );

    assign nand_ce_n = !c_q.ce;
    assign reg_rdata = {8'h00, cap_byte, !rb_sync, 15'h0000};
endmodule

// File: rtl/nrb_chk.sv
module nrb_chk #(
    parameter int unsigned T_PULSE = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic        reg_wait,
    input logic [31:0] reg_rdata,
    input logic        nand_we_n,
    input logic        nand_re_n,
    input logic        nand_cle,
    input logic        nand_ale,
    input logic        nand_io_oe
);
    logic [15:0] we_low_q, re_low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_q <= '0;
            re_low_q <= '0;
        end else begin
            we_low_q <= nand_we_n ? 16'd0 : we_low_q + 16'd1;
            re_low_q <= nand_re_n ? 16'd0 : re_low_q + 16'd1;
        end
    end

    assert_we_re_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    assert_latch_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    assert_read_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_io_oe);

    assert_we_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (we_low_q == 16'(T_PULSE)));

    assert_re_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_re_n) |-> (re_low_q == 16'(T_PULSE)));

    assert_rdata_zero_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & 32'hFF00_7FFF) == 32'h0);

    assert_stall_in_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || reg_rd) && (!nand_we_n || !nand_re_n)) |-> reg_wait);
endmodule

bind nand_reg_bridge nrb_chk #(.T_PULSE(T_PULSE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wait  (reg_wait),
    .reg_rdata (reg_rdata),
    .nand_we_n (nand_we_n),
    .nand_re_n (nand_re_n),
    .nand_cle  (nand_cle),
    .nand_ale  (nand_ale),
    .nand_io_oe(nand_io_oe)
);

// File: tb/sim_nand_reg_bridge.sv
`timescale 1ns/1ps
module sim_nand_reg_bridge;
    localparam int S = 2;
    localparam int P = 3;
    localparam int H = 1;
    localparam int CYC_WAIT = 1 + S + P + H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_wait;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out, nand_io_in;
    logic        nand_rb_n = 1'b1;

    int checks = 0;
    int fails  = 0;
    int rd_ptr = 0;

    int m_we, m_re, m_oe, m_pre;
    logic m_cle, m_ale, m_oe_we, m_oe_re;
    logic [7:0] m_io;

    always #2.5 clk = ~clk;

    assign nand_io_in = 8'(rd_ptr * 37 + 5);

    nand_reg_bridge #(.T_SETUP(S), .T_PULSE(P), .T_HOLD(H), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_wait(reg_wait),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n)
    );

    always @(negedge clk) begin
        if (!nand_we_n) begin
            m_we++;
            m_cle = nand_cle; m_ale = nand_ale; m_io = nand_io_out; m_oe_we = nand_io_oe;
        end
        if (!nand_re_n) begin
            m_re++;
            m_oe_re = m_oe_re | nand_io_oe;
        end
        if (nand_io_oe) begin
            m_oe++;
            if (m_we == 0) m_pre++;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic mon_clear();
        m_we = 0; m_re = 0; m_oe = 0; m_pre = 0;
        m_cle = 0; m_ale = 0; m_oe_we = 0; m_oe_re = 0; m_io = 0;
    endtask

    task automatic access(input bit is_wr, input logic [31:0] wd, output logic [31:0] rd, output int nwait);
        mon_clear();
        nwait = 0;
        reg_wr = is_wr; reg_rd = !is_wr; reg_wdata = wd;
        #1;
        while (reg_wait) begin
            nwait++;
            @(negedge clk); #1;
        end
        rd = reg_rdata;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    logic [7:0] last_byte = 8'h00;

    task automatic do_read(input bit armed);
        logic [31:0] rd;
        int nw;
        logic [7:0] exp_b;
        exp_b = armed ? 8'(rd_ptr * 37 + 5) : last_byte;
        access(1'b0, 32'h0, rd, nw);
        if (armed) begin
            chk("R6", "RE pulse cycles", m_re, P);
            chk("R6", "IO driven during read", m_oe_re, 0);
            chk("R10", "read wait cycles", nw, CYC_WAIT);
            rd_ptr++;
            last_byte = exp_b;
        end else begin
            chk("R7", "RE pulse cycles", m_re, 0);
            chk("R7", "read wait cycles", nw, 0);
        end
        chk(armed ? "R6" : "R7", "read byte", rd[23:16], exp_b);
        chk("R9", "read zero bits", rd & 32'hFF00_FFFF, 0);
    endtask

    task automatic do_write(input logic [2:0] op, input bit ce, input logic [7:0] b);
        logic [31:0] rd;
        int nw;
        bit cyc;
        cyc = (op == 3'd0) || (op == 3'd1) || (op == 3'd3);
        access(1'b1, {ce, op, 4'h0, b, 16'h0}, rd, nw);
        chk("R2", "ce_n after write", nand_ce_n, !ce);
        if (cyc) begin
            chk("R10", "write wait cycles", nw, CYC_WAIT);
            chk("R3", "WE pulse cycles", m_we, P);
            chk("R3", "setup cycles", m_pre, S);
            chk("R3", "drive cycles", m_oe, S + P + H);
            chk("R3", "oe in pulse", m_oe_we, 1);
            chk("R5", "io byte", m_io, b);
            chk("R3", "cle in pulse", m_cle, op == 3'd0);
            chk("R4", "ale in pulse", m_ale, op == 3'd1);
        end else begin
            chk("R1", "no WE pulse", m_we, 0);
            chk("R1", "no drive", m_oe, 0);
            chk("R10", "no-cycle write wait", nw, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12", "ce_n reset", nand_ce_n, 1);
        chk("R12", "we_n reset", nand_we_n, 1);
        chk("R12", "re_n reset", nand_re_n, 1);
        chk("R12", "latches reset", {nand_cle, nand_ale, nand_io_oe}, 0);
        chk("R12", "rdata reset", reg_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "wait idle", reg_wait, 0);

        // R1 R8: every opcode, both enables, several bytes; a read follows each write
        for (int op = 0; op < 8; op++) begin
            for (int ce = 0; ce < 2; ce++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [7:0] b;
                    b = (k == 0) ? 8'h00 : (k == 1) ? 8'hA5 : 8'(op * 16 + ce * 3 + 1);
                    do_write(3'(op), ce[0], b);
                    do_read(op == 2);
                    if (op == 2) begin
                        do_read(1'b1);
                        do_read(1'b1);
                    end
                end
            end
        end

        // R8: arm, then an unused opcode disarms
        do_write(3'd2, 1'b1, 8'h00);
        do_read(1'b1);
        do_write(3'd5, 1'b1, 8'h00);
        do_read(1'b0);
        do_read(1'b0);

        // R5: every data byte on a data-write cycle
        for (int b = 0; b < 256; b++) do_write(3'd3, 1'b1, 8'(b));

        // R9: busy bit through two synchroniser stages
        nand_rb_n = 1'b0;
        @(negedge clk);
        chk("R9", "busy after one edge", reg_rdata[15], 0);
        @(negedge clk);
        chk("R9", "busy after two edges", reg_rdata[15], 1);
        nand_rb_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9", "ready after two edges", reg_rdata[15], 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule